// File: doc/BRIEF.md
# Two-Lane Double-Precision Divider

This block divides one packed pair of IEEE-754 binary64 values by another, lane by lane. A single `start` pulse latches both 128-bit operand words. Each of the two 64-bit lanes then works through its own restoring mantissa division, and both lanes are driven by one shared step counter. After a fixed number of cycles the block raises `done` for one cycle. In that cycle it presents the packed quotient word and the flag vector formed by ORing the flags of both lanes.

A lane first sorts each operand into NaN, infinity, zero or normal. A fixed priority decides whether the lane takes a special result or the rounded quotient. Subnormal inputs count as zeros. Results too small for the normal range are flushed to a signed zero. Results too large become a signed infinity and raise the overflow flag.

Top module: `dp_pair_divider`

## Requirements
- R1: Lane 0 occupies bits [63:0] and lane 1 occupies bits [127:64] of `dividend`, `divisor` and `quotient`. Each lane's result depends only on that lane's operands.
- R2: When a lane's divisor is a NaN, the lane result is the divisor with fraction bit 51 forced to 1. Its sign and its other bits are kept. This holds even when the dividend is also a NaN.
- R3: When the divisor is not a NaN but the dividend is, the lane result is the dividend quieted in the same way as in R2.
- R4: Any NaN operand, quiet or signaling, sets flag bit 0.
- R5: Infinity divided by infinity gives 0x7FF8000000000000 and sets flag bit 1.
- R6: Zero divided by zero gives 0x7FF8000000000000 and sets flag bit 2. An operand with exponent field 0 counts as zero, whatever its fraction.
- R7: A finite nonzero dividend divided by zero gives an infinity whose sign is the XOR of the operand signs, and sets flag bit 3.
- R8: Infinity divided by a finite value or by zero gives a signed infinity. Zero divided by a nonzero value, and finite divided by infinity, give a signed zero. In each case the sign is the XOR of the operand signs and no flag is set.
- R9: For two normal operands, the result is the exact quotient rounded to nearest, ties to even, in binary64. No flag is set.
- R10: A normal quotient whose rounded exponent exceeds the largest finite exponent becomes a signed infinity and sets flag bit 4. A quotient below the smallest normal magnitude becomes a signed zero with no flag.
- R11: Let the rising edge that samples `start` be edge 0. Then `done`, `quotient` and `flags` update at edge 57, and `done` is high for exactly that one cycle. `quotient` holds its value until the next completion.
- R12: A `start` that arrives while an operation is in progress is ignored. The running operation's result and timing are unchanged, and no extra `done` follows.
- R13: After reset, `quotient`, `done` and `flags` are 0. `flags` is 0 in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a division with the present operands |
| dividend | input | 128 | Packed dividends, lane 1 in the upper half |
| divisor | input | 128 | Packed divisors, lane 1 in the upper half |
| quotient | output | 128 | Packed lane results, held between completions |
| done | output | 1 | One-cycle completion pulse |
| flags | output | 5 | Lane flags ORed, valid with `done`: bit0 NaN operand, bit1 inf/inf, bit2 zero/zero, bit3 divide by zero, bit4 overflow |

## Verification
Every result of this block lands at the same point: the rising edge 57 edges after the one that samples `start`, whichever path a lane took, special or divided. The bench drives each operand pair on a falling edge. It checks at the falling edge after edge 56 that `done` is still low, and samples `quotient` and `flags` at the falling edge after edge 57. It then confirms one falling edge later that `done` has dropped. The mid-run `start` test keeps to the same schedule and counts every `done` pulse until well after the first completion.

// File: rtl/dpdiv_pkg.sv
// Shared widths, flag positions, operand class type and NaN helpers for
// the packed divider. Assumes a binary interchange format with an
// explicit sign, biased exponent and hidden leading one.
package dpdiv_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SIG_W  = FRAC_W + 1;          // significand with hidden one
    localparam int Q_W    = SIG_W + 3;           // quotient bits incl. spare, guard, round
    localparam int REM_W  = SIG_W + 1;           // partial remainder
    localparam int E_W    = EXP_W + 2;           // signed working exponent
    localparam int ITER   = Q_W;                 // one quotient bit per step

    localparam int F_NAN  = 0;
    localparam int F_IINF = 1;
    localparam int F_ZZ   = 2;
    localparam int F_DZ   = 3;
    localparam int F_OVF  = 4;
    localparam int FLG_W  = 5;

    typedef struct packed {
        logic nan;
        logic inf;
        logic zero;
    } opcls_t;

    localparam logic [WORD_W-1:0] QNAN_DEF =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    // Force the top fraction bit of a NaN, keeping sign and payload.
    function automatic logic [WORD_W-1:0] quieten(input logic [WORD_W-1:0] x);
        logic [WORD_W-1:0] y;
        y = x;
        y[FRAC_W-1] = 1'b1;
        return y;
    endfunction

    // Signed infinity with the given sign.
    function automatic logic [WORD_W-1:0] inf_of(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction
endpackage

// File: rtl/dpdiv_classify.sv
// Sorts one operand into NaN, infinity or zero. Anything else is normal.
// A zero exponent field counts as zero, so subnormals are flushed here.
module dpdiv_classify
    import dpdiv_pkg::*;
(
    input  logic [WORD_W-1:0] x,
    output opcls_t            cls
);
    logic exp_ones;
    logic exp_zero;
    logic frac_nz;

    // Field tests feeding the class bits.
    always_comb begin
        exp_ones = &x[WORD_W-2:FRAC_W];
        exp_zero = ~|x[WORD_W-2:FRAC_W];
        frac_nz  = |x[FRAC_W-1:0];
        cls.nan  = exp_ones & frac_nz;
        cls.inf  = exp_ones & ~frac_nz;
        cls.zero = exp_zero;
    end
endmodule

// File: rtl/dpdiv_ctrl.sv
// Shared sequencer. It accepts start only while idle, issues ITER step
// cycles, then one finish cycle, and registers done from the finish cycle.
module dpdiv_ctrl #(
    parameter int ITER = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic fin,
    output logic done
);
    localparam int CNT_W = $clog2(ITER + 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;

    // Decode the phase of the current cycle.
    always_comb begin
        load = start && !busy;
        step = busy && (cnt != '0);
        fin  = busy && (cnt == '0);
    end

    // Busy flag, step counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= fin;
            if (load) begin
                busy <= 1'b1;
                cnt  <= CNT_W'(ITER);
            end else if (step) begin
                cnt  <= cnt - 1'b1;
            end else if (fin) begin
                busy <= 1'b0;
            end
        end
    end

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r12_count_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (busy && cnt == $past(cnt) - 1'b1));
    a_r12_no_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |-> !load);
endmodule

// File: rtl/dpdiv_lane.sv
// One lane. On load it picks a special result by fixed priority and sets up
// the restoring divider. Step cycles develop one quotient bit each. On fin
// it rounds to nearest even and registers the result and flags.
// It assumes the controller issues exactly ITER steps between load and fin.
module dpdiv_lane
    import dpdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              fin,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] res,
    output logic [FLG_W-1:0]  flg
);
    localparam logic [E_W-1:0] EXP_MAX = E_W'((1 << EXP_W) - 1);
    localparam logic [E_W-1:0] EXP_MIN = E_W'(1);

    opcls_t ca, cb;
    logic   sgn;

    dpdiv_classify u_cls_a (.x(op_a), .cls(ca));
    dpdiv_classify u_cls_b (.x(op_b), .cls(cb));

    logic              spec_hit;
    logic [WORD_W-1:0] spec_val;
    logic [FLG_W-1:0]  spec_flg;

    // Special-case priority: NaN divisor, NaN dividend, inf/inf, 0/0, inf/x, x/0, 0/x or x/inf.
    always_comb begin
        sgn      = op_a[WORD_W-1] ^ op_b[WORD_W-1];
        spec_hit = 1'b1;
        spec_val = '0;
        spec_flg = '0;
        if (cb.nan) begin
            spec_val        = quieten(op_b);
            spec_flg[F_NAN] = 1'b1;
        end else if (ca.nan) begin
            spec_val        = quieten(op_a);
            spec_flg[F_NAN] = 1'b1;
        end else if (ca.inf && cb.inf) begin
            spec_val         = QNAN_DEF;
            spec_flg[F_IINF] = 1'b1;
        end else if (ca.zero && cb.zero) begin
            spec_val       = QNAN_DEF;
            spec_flg[F_ZZ] = 1'b1;
        end else if (ca.inf) begin
            spec_val = inf_of(sgn);
        end else if (cb.zero) begin
            spec_val       = inf_of(sgn);
            spec_flg[F_DZ] = 1'b1;
        end else if (ca.zero || cb.inf) begin
            spec_val = {sgn, {(WORD_W-1){1'b0}}};
        end else begin
            spec_hit = 1'b0;
        end
    end

    logic              spec_q;
    logic [WORD_W-1:0] spec_val_q;
    logic [FLG_W-1:0]  spec_flg_q;
    logic              sgn_q;
    logic [E_W-1:0]    expd_q;
    logic [SIG_W-1:0]  div_q;
    logic [REM_W-1:0]  rem_q;
    logic [Q_W-1:0]    quo_q;

    logic              rem_ge;
    logic [REM_W-1:0]  rem_nxt;

    // One restoring step: subtract if it fits, then shift left.
    always_comb begin
        rem_ge  = rem_q >= {1'b0, div_q};
        rem_nxt = (rem_ge ? (rem_q - {1'b0, div_q}) : rem_q) << 1;
    end

    logic              hi;
    logic [SIG_W-1:0]  mant;
    logic              grd;
    logic              stk;
    logic              rnd_up;
    logic [SIG_W:0]    sum;
    logic              carry;
    logic              norm_ok;
    logic [E_W-1:0]    e_fin;
    logic              ovf;
    logic              unf;
    logic [WORD_W-1:0] norm_val;

    // Normalize, round to nearest even and range-check the quotient.
    always_comb begin
        hi      = quo_q[Q_W-1];
        mant    = hi ? quo_q[Q_W-1 -: SIG_W] : quo_q[Q_W-2 -: SIG_W];
        grd     = hi ? quo_q[2] : quo_q[1];
        stk     = (hi ? (|quo_q[1:0]) : quo_q[0]) | (|rem_q);
        rnd_up  = grd & (stk | mant[0]);
        sum     = {1'b0, mant} + (SIG_W+1)'(rnd_up);
        carry   = sum[SIG_W];
        norm_ok = sum[SIG_W] | sum[SIG_W-1];
        e_fin   = expd_q - E_W'(!hi) + E_W'(carry);
        ovf     = $signed(e_fin) >= $signed(EXP_MAX);
        unf     = $signed(e_fin) < $signed(EXP_MIN);
        if (ovf)
            norm_val = inf_of(sgn_q);
        else if (unf || !norm_ok)
            norm_val = {sgn_q, {(WORD_W-1){1'b0}}};
        else
            norm_val = {sgn_q, e_fin[EXP_W-1:0], sum[FRAC_W-1:0]};
    end

    // Operand capture, divider iteration and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_q     <= 1'b0;
            spec_val_q <= '0;
            spec_flg_q <= '0;
            sgn_q      <= 1'b0;
            expd_q     <= '0;
            div_q      <= '0;
            rem_q      <= '0;
            quo_q      <= '0;
            res        <= '0;
            flg        <= '0;
        end else begin
            flg <= '0;
            if (load) begin
                spec_q     <= spec_hit;
                spec_val_q <= spec_val;
                spec_flg_q <= spec_flg;
                sgn_q      <= sgn;
                expd_q     <= E_W'(op_a[WORD_W-2:FRAC_W]) - E_W'(op_b[WORD_W-2:FRAC_W])
                              + E_W'(BIAS);
                div_q      <= {1'b1, op_b[FRAC_W-1:0]};
                rem_q      <= {2'b01, op_a[FRAC_W-1:0]};
                quo_q      <= '0;
            end else if (step) begin
                rem_q <= rem_nxt;
                quo_q <= {quo_q[Q_W-2:0], rem_ge};
            end else if (fin) begin
                res <= spec_q ? spec_val_q : norm_val;
                flg <= spec_q ? spec_flg_q : (FLG_W'(ovf) << F_OVF);
            end
        end
    end

    a_r9_norm_mantissa: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !spec_q) |-> norm_ok);
    a_r9_divide_gives_no_nan: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !spec_q) |=> !((&res[WORD_W-2:FRAC_W]) && (|res[FRAC_W-1:0])));
    a_r2_nan_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && spec_q && spec_flg_q[F_NAN]) |=> (res[FRAC_W-1] && (&res[WORD_W-2:FRAC_W])));
    a_r10_ovf_means_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !spec_q) |=> (flg[F_OVF] == (res[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}})));
endmodule

// File: rtl/dp_pair_divider.sv
// Top level: LANES independent binary64 division lanes under one sequencer.
// Lane k sits at bits [k*64 +: 64]. The lane flags are ORed into one vector
// that is nonzero only while done is high.
module dp_pair_divider
    import dpdiv_pkg::*;
#(
    parameter int LANES = 2,
    localparam int VEC_W = LANES * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VEC_W-1:0] dividend,
    input  logic [VEC_W-1:0] divisor,
    output logic [VEC_W-1:0] quotient,
    output logic             done,
    output logic [FLG_W-1:0] flags
);
    logic load, step, fin;
    logic [FLG_W-1:0] lane_flg [LANES];

    dpdiv_ctrl #(.ITER(ITER)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .fin   (fin),
        .done  (done)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        dpdiv_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .step  (step),
            .fin   (fin),
            .op_a  (dividend[k*WORD_W +: WORD_W]),
            .op_b  (divisor[k*WORD_W +: WORD_W]),
            .res   (quotient[k*WORD_W +: WORD_W]),
            .flg   (lane_flg[k])
        );
    end

    // OR the per-lane flags into the shared vector.
    always_comb begin
        flags = '0;
        for (int k = 0; k < LANES; k++)
            flags = flags | lane_flg[k];
    end

    a_r13_flags_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (flags == '0));
    a_r11_done_follows_finish: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fin));
endmodule

// File: tb/tb_dp_pair_divider.sv
module tb_dp_pair_divider;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] dividend = '0;
    logic [127:0] divisor = '0;
    logic [127:0] quotient;
    logic         done;
    logic [4:0]   flags;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int done_seen = 0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    always #4 clk = ~clk;   // 125 MHz

    dp_pair_divider dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .done(done), .flags(flags)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done) done_seen <= done_seen + 1;
        if (cyc > 200000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got no finish, expected end before 200000 cycles");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_vec = n_vec + 1;
        if (got !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] next_rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    // Expected lane result from the requirement rules, with real division for R9/R10.
    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  output logic [63:0] r, output logic [4:0] f,
                                  output string tag);
        logic an, bn, ai, bi, az, bz, s;
        logic [63:0] qb;
        real q;
        an = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
        bn = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
        ai = (a[62:52] == 11'h7FF) && (a[51:0] == 0);
        bi = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
        az = (a[62:52] == 0);
        bz = (b[62:52] == 0);
        s  = a[63] ^ b[63];
        f  = 5'd0;
        if (bn) begin
            r = b | (64'd1 << 51); f[0] = 1'b1; tag = "R2/R4";
        end else if (an) begin
            r = a | (64'd1 << 51); f[0] = 1'b1; tag = "R3/R4";
        end else if (ai && bi) begin
            r = 64'h7FF8000000000000; f[1] = 1'b1; tag = "R5";
        end else if (az && bz) begin
            r = 64'h7FF8000000000000; f[2] = 1'b1; tag = "R6";
        end else if (ai) begin
            r = {s, 11'h7FF, 52'd0}; tag = "R8";
        end else if (bz) begin
            r = {s, 11'h7FF, 52'd0}; f[3] = 1'b1; tag = "R7";
        end else if (az || bi) begin
            r = {s, 63'd0}; tag = "R8";
        end else begin
            q  = $bitstoreal(a) / $bitstoreal(b);
            qb = $realtobits(q);
            tag = "R9";
            if (qb[62:52] == 11'h7FF) begin
                f[4] = 1'b1; tag = "R10";
                r = {s, 11'h7FF, 52'd0};
            end else if (qb[62:52] == 0) begin
                r = {s, 63'd0}; tag = "R10";
            end else begin
                r = qb;
            end
        end
    endfunction

    function automatic logic [63:0] pick(input int i);
        case (i)
            0:  return 64'h0000000000000000;
            1:  return 64'h8000000000000000;
            2:  return 64'h7FF0000000000000;
            3:  return 64'hFFF0000000000000;
            4:  return 64'h7FF8000000000001;
            5:  return 64'h7FF0000000000005;
            6:  return 64'h3FF0000000000000;
            7:  return 64'hC008000000000000;
            8:  return 64'h3FF8000000000000;
            9:  return 64'h401C000000000000;
            10: return 64'h7FEFFFFFFFFFFFFF;
            11: return 64'h0010000000000000;
            12: return 64'h0000000000000001;
            13: return 64'h3FB999999999999A;
            14: return 64'h7E37E43C8800759C;
            default: return 64'hFFF4000000000000;
        endcase
    endfunction

    // Apply one vector and check timing (R11), lanes (R1) and flags at edge 57.
    task automatic run_vec(input logic [63:0] a0, input logic [63:0] b0,
                           input logic [63:0] a1, input logic [63:0] b1);
        logic [63:0] e0, e1;
        logic [4:0]  f0, f1;
        string t0, t1;
        model(a0, b0, e0, f0, t0);
        model(a1, b1, e1, f1, t1);
        @(negedge clk);
        dividend = {a1, a0};
        divisor  = {b1, b0};
        start = 1'b1;
        @(negedge clk);              // edge 0 has sampled start
        start = 1'b0;
        repeat (56) @(negedge clk);
        check64("R11 done early", {63'd0, done}, 64'd0);
        @(negedge clk);              // after edge 57
        check64("R11 done due", {63'd0, done}, 64'd1);
        check64({"R1 lane0 ", t0}, quotient[63:0], e0);
        check64({"R1 lane1 ", t1}, quotient[127:64], e1);
        check64({"flags ", t0, " ", t1}, {59'd0, flags}, {59'd0, f0 | f1});
        @(negedge clk);
        check64("R11 done one cycle", {63'd0, done}, 64'd0);
        check64("R13 flags low without done", {59'd0, flags}, 64'd0);
        check64("R11 result held", quotient, {e1, e0});
    endtask

    function automatic logic [63:0] rnd_op(input bit wide);
        logic [63:0] x;
        int e;
        x = next_rnd();
        if (wide) e = 1 + (int'(x[62:52]) % 2046);
        else      e = 1023 - 400 + (int'(x[62:52]) % 801);
        x[62:52] = 11'(e);
        return x;
    endfunction

    initial begin
        logic [63:0] ea, ex;
        logic [4:0]  ef;
        string et;
        int base;
        repeat (3) @(negedge clk);
        // R13: reset state
        check64("R13 quotient reset", quotient, 64'd0);
        check64("R13 done reset", {63'd0, done}, 64'd0);
        check64("R13 flags reset", {59'd0, flags}, 64'd0);
        rst_n = 1'b1;

        // Full sweep of the special and normal value set (R2..R10), with
        // lane 1 paired differently so lanes disagree (R1).
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
                run_vec(pick(i), pick(j), pick(j), pick((i + 5) % 16));

        // Random normal operands (R9), some across the full exponent range (R10).
        for (int n = 0; n < 400; n++) begin
            logic [63:0] a0, b0, a1, b1;
            a0 = rnd_op(n % 4 == 0); b0 = rnd_op(n % 4 == 0);
            a1 = rnd_op(n % 3 == 0); b1 = rnd_op(n % 3 == 0);
            run_vec(a0, b0, a1, b1);
        end

        // R12: a start while busy is ignored.
        model(64'h4000000000000000, 64'h4008000000000000, ea, ef, et);
        model(64'h3FF0000000000000, 64'h4014000000000000, ex, ef, et);
        @(negedge clk);
        base = done_seen;
        dividend = {64'h3FF0000000000000, 64'h4000000000000000};
        divisor  = {64'h4014000000000000, 64'h4008000000000000};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        dividend = {64'h7FF0000000000000, 64'h0000000000000000};
        divisor  = {64'h0000000000000000, 64'h0000000000000000};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (36) @(negedge clk);  // now after edge 57 of the first start
        check64("R12 done on schedule", {63'd0, done}, 64'd1);
        check64("R12 lane0 unchanged", quotient[63:0], ea);
        check64("R12 lane1 unchanged", quotient[127:64], ex);
        check64("R12 flags unchanged", {59'd0, flags}, 64'd0);
        repeat (80) @(negedge clk);
        check64("R12 single done pulse", 64'(done_seen - base), 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule